// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page address. It walks a three-level page table held in memory and returns the granted read, write and execute rights, together with either success or a fault code. Each request carries the address, a mask of the access the caller needs, and a 2-bit privilege index, where 0 is the kernel. The walker reads one 64-bit table entry per level through a simple read port. It starts from a table base that the surrounding logic supplies. A direct-mapped kernel window is translated with no memory traffic at all. The walker handles one translation at a time.

There are three streams, and each uses valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle. A memory read is issued by holding `mem_req_valid` with a stable address until `mem_req_ready`. The memory answers with a single-cycle `mem_rsp_valid` pulse one or more cycles after that handshake, so the read latency may vary. The result is presented on `rsp_valid` and is held unchanged until `rsp_ready`. A slow consumer therefore back-pressures the walker, and the walker stays busy until the result is taken.

Top module: `pt3_walker`

## Requirements
- R1: An address whose bits 63 down to 43 are not all equal to bit 63 ends with fault code 1 (access violation), paddr 0 and perm 0, and no memory read is made.
- R2: A well-formed address is a kernel window address when bit 63 is 1 and bits 42:41 are 2'b10. With privilege 0, the result is fault 0, perm 3'b111, and paddr equal to address bits 39:0 with address bit 40 placed at paddr bit 43. No memory read is made.
- R3: A kernel window address requested with a privilege other than 0 ends with fault 1, paddr 0 and perm 0.
- R4: Level k (k = 0, 1, 2) reads the entry at base + 8*index. The index is address bits [42-10k : 33-10k]. The base for level 0 is `table_base`. The base for each later level is entry bits 63:32 shifted left by 13.
- R5: An entry whose bit 0 (valid) is clear ends the walk with fault 2 (not valid). At the last level, paddr is still that entry's frame shifted left by 13 and perm is 0. At earlier levels paddr and perm are 0.
- R6: A level-0 or level-1 entry whose bit 8 (kernel read enable) is clear ends the walk with fault 1, paddr 0 and perm 0. No further level is read.
- R7: On the last entry, read and execute are granted by entry bit (8 + privilege), and write is granted by entry bit (12 + privilege). Perm bit 0 is read, bit 1 is write and bit 2 is execute. If the need mask is non-zero and shares no bit with these rights, the result is fault 1, with perm equal to the rights before masking.
- R8: The rights are then cleared by entry bits 1 (read), 2 (write) and 3 (execute), and the masked rights are returned as perm. If the need then shares no bit with perm, the fault is 5 (fault on execute) when the need includes execute. Otherwise it is 4 (fault on write) when the need includes write. Otherwise it is 3 (fault on read).
- R9: A need mask of 0 never faults at the last level when the entry is valid. Such a result is fault 0 with the masked rights.
- R10: `busy` rises the cycle after a request is accepted and falls the cycle after the response handshake. `req_ready` is the inverse of `busy`. While `rsp_ready` is low, `rsp_valid` and the result fields hold.
- R11: Each level makes exactly one memory read. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| table_base | input | 45 | Physical address of the level-0 table, sampled when a request is taken |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_need | input | 3 | Required access mask: bit 0 read, bit 1 write, bit 2 execute |
| req_priv | input | 2 | Privilege index, 0 = kernel |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 45 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 64 | Table entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 45 | Physical page address |
| rsp_perm | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| rsp_fault | output | 3 | 0 none, 1 access, 2 not valid, 3 on read, 4 on write, 5 on execute |
| busy | output | 1 | Translation in flight |

## Verification
The bench targets the kernel window and checks that address bit 40 lands at bit 43. A design that kept bit 40 in place, or that walked memory for this range, would show a wrong page address or extra reads. It also covers a negative but well-formed address outside the window, which must still walk. It covers a last-level invalid entry, where the frame must still appear, and the user privilege shift, where a design reading only the kernel bits would grant or deny the wrong rights. Needs that combine several fault-on bits check the execute-then-write-then-read order, and a zero need must succeed. Stall patterns on both the read port and the result port catch a design that drops held values or issues duplicate reads.

// File: rtl/pt3_pkg.sv
package pt3_pkg;

  // Fault codes returned with each translation
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ACCESS    = 3'd1,
    FLT_NOT_VALID = 3'd2,
    FLT_ON_READ   = 3'd3,
    FLT_ON_WRITE  = 3'd4,
    FLT_ON_EXEC   = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_e;

  // Table entry layout
  localparam int PTE_VALID     = 0;
  localparam int PTE_FO_LSB    = 1;   // bits 1..3: fault on read, write, execute
  localparam int PTE_RD_EN_LSB = 8;   // plus privilege index
  localparam int PTE_WR_EN_LSB = 12;  // plus privilege index
  localparam int PTE_FRAME_LSB = 32;
  localparam int PTE_FRAME_W   = 32;

  // Kernel window decode
  localparam int       WIN_SEL_HI  = 42;
  localparam int       WIN_SEL_LO  = 41;
  localparam logic [1:0] WIN_SEL_CODE = 2'b10;
  localparam int       WIN_KEEP_W  = 40;  // bits kept in place
  localparam int       WIN_MOVE_SRC = 40; // bit relocated
  localparam int       WIN_MOVE_DST = 43;

  localparam logic [1:0] KERNEL_PRIV = 2'd0;

endpackage

// File: rtl/pt3_va_check.sv
module pt3_va_check
  import pt3_pkg::*;
#(
  parameter int VA_BITS = 43,
  parameter int PA_W    = 45
) (
  input  logic [63:0]     vaddr,
  input  logic [1:0]      priv,
  output logic            sign_ok,
  output logic            in_window,
  output logic            window_ok,
  output logic [PA_W-1:0] window_paddr
);

  logic [63-VA_BITS:0] upper;

  assign upper     = vaddr[63:VA_BITS];
  assign sign_ok   = (&upper) | ~(|upper);
  assign in_window = vaddr[63] & (vaddr[WIN_SEL_HI:WIN_SEL_LO] == WIN_SEL_CODE);
  assign window_ok = (priv == KERNEL_PRIV);

  always_comb begin
    window_paddr = '0;
    window_paddr[WIN_KEEP_W-1:0] = vaddr[WIN_KEEP_W-1:0];
    window_paddr[WIN_MOVE_DST]   = vaddr[WIN_MOVE_SRC];
  end

endmodule

// File: rtl/pt3_index_sel.sv
module pt3_index_sel #(
  parameter int LEVELS    = 3,
  parameter int IDX_BITS  = 10,
  parameter int PAGE_BITS = 13,
  parameter int PA_W      = 45,
  parameter int LVL_W     = 2
) (
  input  logic [63:0]      vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  entry_addr
);

  localparam int IDX_TOP = PAGE_BITS + IDX_BITS * LEVELS;

  logic [IDX_BITS-1:0] idx_arr [LEVELS];
  logic [IDX_BITS-1:0] idx_sel;
  logic                unused_va_bits;

  // Level 0 takes the highest index field, the last level the lowest
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign idx_arr[l] = vaddr[PAGE_BITS + IDX_BITS*(LEVELS-1-l) +: IDX_BITS];
  end

  always_comb begin
    idx_sel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) idx_sel = idx_arr[l];
    end
  end

  assign entry_addr     = base + (PA_W'(idx_sel) << 3);
  assign unused_va_bits = ^{vaddr[63:IDX_TOP], vaddr[PAGE_BITS-1:0]};

endmodule

// File: rtl/pt3_pte_eval.sv
module pt3_pte_eval
  import pt3_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int PA_W      = 45
) (
  input  logic [63:0]     pte,
  input  logic            is_leaf,
  input  logic [2:0]      need,
  input  logic [1:0]      priv,
  output logic [PA_W-1:0] page_addr,
  output logic [2:0]      perm,
  output fault_e          fault
);

  logic       rd_en, wr_en;
  logic [2:0] granted, kept, fault_on;
  logic       unused_pte_bits;

  assign page_addr = {pte[PTE_FRAME_LSB +: PTE_FRAME_W], {PAGE_BITS{1'b0}}};
  assign rd_en     = pte[PTE_RD_EN_LSB + int'(priv)];
  assign wr_en     = pte[PTE_WR_EN_LSB + int'(priv)];
  assign granted   = {rd_en, wr_en, rd_en};   // execute, write, read
  assign fault_on  = pte[PTE_FO_LSB +: 3];
  assign kept      = granted & ~fault_on;

  assign unused_pte_bits = ^{pte[31:16], pte[7:4]};

  always_comb begin
    perm  = '0;
    fault = FLT_NONE;
    if (!pte[PTE_VALID]) begin
      fault = FLT_NOT_VALID;
    end else if (!is_leaf) begin
      if (!pte[PTE_RD_EN_LSB]) fault = FLT_ACCESS;
    end else if ((need != 3'b000) && ((granted & need) == 3'b000)) begin
      perm  = granted;
      fault = FLT_ACCESS;
    end else begin
      perm = kept;
      if ((kept & need) == 3'b000) begin
        if (need[2])      fault = FLT_ON_EXEC;
        else if (need[1]) fault = FLT_ON_WRITE;
        else if (need[0]) fault = FLT_ON_READ;
      end
    end
  end

endmodule

// File: rtl/pt3_walker.sv
module pt3_walker
  import pt3_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int LEVELS    = 3,
  parameter int IDX_BITS  = 10,
  localparam int PA_W     = PTE_FRAME_W + PAGE_BITS,
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] table_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [2:0]      req_need,
  input  logic [1:0]      req_priv,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [2:0]      rsp_perm,
  output logic [2:0]      rsp_fault,
  output logic            busy
);

  walk_state_e     state;
  logic [LVL_W-1:0] level;
  logic [PA_W-1:0] base_q;
  logic [63:0]     vaddr_q;
  logic [2:0]      need_q;
  logic [1:0]      priv_q;
  logic [PA_W-1:0] paddr_q;
  logic [2:0]      perm_q;
  fault_e          fault_q;

  logic            va_sign_ok, va_window, va_window_ok;
  logic [PA_W-1:0] va_window_paddr;
  logic [PA_W-1:0] entry_addr;
  logic            at_leaf;
  logic [PA_W-1:0] pte_page;
  logic [2:0]      pte_perm;
  fault_e          pte_fault;

  pt3_va_check #(.VA_BITS(VA_BITS), .PA_W(PA_W)) u_va_check (
    .vaddr        (req_vaddr),
    .priv         (req_priv),
    .sign_ok      (va_sign_ok),
    .in_window    (va_window),
    .window_ok    (va_window_ok),
    .window_paddr (va_window_paddr)
  );

  pt3_index_sel #(
    .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PAGE_BITS(PAGE_BITS),
    .PA_W(PA_W), .LVL_W(LVL_W)
  ) u_index_sel (
    .vaddr      (vaddr_q),
    .level      (level),
    .base       (base_q),
    .entry_addr (entry_addr)
  );

  assign at_leaf = (level == LVL_W'(LEVELS - 1));

  pt3_pte_eval #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_pte_eval (
    .pte       (mem_rsp_data),
    .is_leaf   (at_leaf),
    .need      (need_q),
    .priv      (priv_q),
    .page_addr (pte_page),
    .perm      (pte_perm),
    .fault     (pte_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      level   <= '0;
      base_q  <= '0;
      vaddr_q <= '0;
      need_q  <= '0;
      priv_q  <= '0;
      paddr_q <= '0;
      perm_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            need_q  <= req_need;
            priv_q  <= req_priv;
            level   <= '0;
            base_q  <= table_base;
            paddr_q <= '0;
            perm_q  <= '0;
            fault_q <= FLT_NONE;
            if (!va_sign_ok) begin
              fault_q <= FLT_ACCESS;
              state   <= ST_DONE;
            end else if (va_window) begin
              if (va_window_ok) begin
                paddr_q <= va_window_paddr;
                perm_q  <= 3'b111;
              end else begin
                fault_q <= FLT_ACCESS;
              end
              state <= ST_DONE;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (at_leaf) begin
              paddr_q <= pte_page;
              perm_q  <= pte_perm;
              fault_q <= pte_fault;
              state   <= ST_DONE;
            end else if (pte_fault != FLT_NONE) begin
              fault_q <= pte_fault;
              state   <= ST_DONE;
            end else begin
              base_q <= pte_page;
              level  <= level + LVL_W'(1);
              state  <= ST_ISSUE;
            end
          end
        end
        ST_DONE: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = entry_addr;
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_perm      = perm_q;
  assign rsp_fault     = fault_q;

  // R10: result held under back-pressure
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) &&
                                $stable(rsp_perm) && $stable(rsp_fault));

  // R11: read request held until accepted
  p_memreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R1: malformed address answers at once with an access fault
  p_sign_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !va_sign_ok |=>
      rsp_valid && (rsp_fault == FLT_ACCESS) && !mem_req_valid);

  // R2: kernel window answers with no table read
  p_window_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && va_sign_ok && va_window |=> rsp_valid && !mem_req_valid);

  // R8: a successful translation grants part of the need
  p_success_grants_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == FLT_NONE) && (need_q != 3'b000) |->
      ((rsp_perm & need_q) != 3'b000));

  // R4: level counter stays within the table depth
  p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(level) < LEVELS));

endmodule

// File: tb/pt3_walker_test.sv
`timescale 1ns/1ps
module pt3_walker_test;

  localparam logic [44:0] PTBR = 45'h20000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [63:0] req_vaddr = '0;
  logic [2:0]  req_need = '0;
  logic [1:0]  req_priv = '0;
  logic        mem_req_ready = 0;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_ready = 0;
  logic        req_ready, mem_req_valid, rsp_valid, busy;
  logic [44:0] mem_req_addr, rsp_paddr;
  logic [2:0]  rsp_perm, rsp_fault;

  pt3_walker uut (
    .clk(clk), .rst_n(rst_n), .table_base(PTBR),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_need(req_need), .req_priv(req_priv),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .busy(busy)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] mem [logic [44:0]];
  logic [44:0] exp_addr_q [$];
  logic [44:0] exp_pa;
  logic [2:0]  exp_perm;
  int          exp_fault;
  string       cur_tag = "R10";
  bit          resp_seen = 0;
  bit          exp_busy = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] rd(input logic [44:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] frame, input logic [15:0] flags);
    return {frame, 16'h0, flags};
  endfunction

  function automatic logic [63:0] va_of(input int i1, input int i2, input int i3, input int off);
    return {21'h0, 10'(i1), 10'(i2), 10'(i3), 13'(off)};
  endfunction

  // Behavioural reference of a whole translation
  task automatic ref_walk(input logic [63:0] va, input logic [2:0] need, input logic [1:0] priv);
    logic [44:0] base, a;
    logic [63:0] e;
    logic [2:0]  p;
    bit          bad;
    int          idx;
    exp_pa = '0; exp_perm = '0; exp_fault = 0; bad = 0;
    for (int b = 43; b < 63; b++) if (va[b] != va[63]) bad = 1;
    if (bad) begin exp_fault = 1; return; end
    if (va[63] && va[42:41] == 2'b10) begin
      if (priv != 2'd0) begin exp_fault = 1; return; end
      exp_pa = 45'(va[39:0]) | (45'(va[40]) << 43);
      exp_perm = 3'b111;
      return;
    end
    base = PTBR;
    for (int lvl = 0; lvl < 3; lvl++) begin
      idx = int'((va >> (13 + 10 * (2 - lvl))) & 64'h3ff);
      a = base + 45'(idx * 8);
      exp_addr_q.push_back(a);
      e = rd(a);
      if (lvl < 2) begin
        if (!e[0]) begin exp_fault = 2; return; end
        if (!e[8]) begin exp_fault = 1; return; end
        base = 45'(e[63:32]) << 13;
      end else begin
        exp_pa = 45'(e[63:32]) << 13;
        if (!e[0]) begin exp_fault = 2; return; end
        p = {e[8 + priv], e[12 + priv], e[8 + priv]};
        if (need != 0 && (p & need) == 0) begin exp_perm = p; exp_fault = 1; return; end
        p = p & ~e[3:1];
        exp_perm = p;
        if ((p & need) == 0)
          exp_fault = need[2] ? 5 : need[1] ? 4 : need[0] ? 3 : 0;
      end
    end
  endtask

  // Memory model: stalls the request port, variable latency
  bit          m_pend = 0;
  int          m_lat = 0;
  logic [44:0] m_addr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 0; mem_rsp_valid = 0; m_pend = 0;
    end else begin
      mem_rsp_valid = 0;
      mem_rsp_data = 64'hA5A5_5A5A_F0F0_0F0F;
      if (m_pend) begin
        if (m_lat == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd(m_addr); m_pend = 0;
        end else m_lat--;
      end
      mem_req_ready = (cyc % 5) != 3;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0) chk(0, "R11", "unexpected read", 64'(mem_req_addr), 64'h0);
        else begin
          logic [44:0] ea;
          ea = exp_addr_q.pop_front();
          chk(mem_req_addr == ea, "R4", "entry address", 64'(mem_req_addr), 64'(ea));
        end
        m_pend = 1; m_lat = cyc % 3; m_addr = mem_req_addr;
      end
    end
  end

  // Cycle model of the handshakes and result comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == exp_busy, "R10", "busy", 64'(busy), 64'(exp_busy));
      chk(req_ready == !exp_busy, "R10", "req_ready", 64'(req_ready), 64'(!exp_busy));
      rsp_ready = (cyc % 3) != 2;
      if (rsp_valid && rsp_ready) begin
        chk(rsp_fault == 3'(exp_fault), cur_tag, "fault", 64'(rsp_fault), 64'(exp_fault));
        chk(rsp_paddr == exp_pa, cur_tag, "paddr", 64'(rsp_paddr), 64'(exp_pa));
        chk(rsp_perm == exp_perm, cur_tag, "perm", 64'(rsp_perm), 64'(exp_perm));
        chk(exp_addr_q.size() == 0, "R11", "missing reads", 64'(exp_addr_q.size()), 64'h0);
        resp_seen = 1;
        exp_busy = 0;
      end else if (req_valid && !exp_busy) begin
        exp_busy = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_walk(input logic [63:0] va, input logic [2:0] need,
                         input logic [1:0] priv, input string tag);
    ref_walk(va, need, priv);
    cur_tag = tag;
    resp_seen = 0;
    @(posedge clk); #2;
    req_valid = 1; req_vaddr = va; req_need = need; req_priv = priv;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 0;
    do @(negedge clk); while (!resp_seen);
  endtask

  initial begin
    // Tables: level-1 table at frame 0x40, level-2 table at frame 0x41
    mem[PTBR + 45'(5 * 8)] = mk(32'h40, 16'h0101);
    mem[PTBR + 45'(7 * 8)] = mk(32'h48, 16'h0001);          // no kernel read
    mem[(45'h40 << 13) + 45'(7 * 8)] = mk(32'h41, 16'h0101);
    mem[(45'h40 << 13) + 45'(9 * 8)] = mk(32'h49, 16'h0001); // no kernel read
    mem[(45'h41 << 13) + 45'(9 * 8)]  = mk(32'h1234, 16'h1101);
    mem[(45'h41 << 13) + 45'(10 * 8)] = mk(32'h2222, 16'h0101);
    mem[(45'h41 << 13) + 45'(11 * 8)] = mk(32'h3333, 16'h8801);
    mem[(45'h41 << 13) + 45'(12 * 8)] = mk(32'h0044, 16'h1109);
    mem[(45'h41 << 13) + 45'(13 * 8)] = mk(32'h0045, 16'h110F);
    mem[(45'h41 << 13) + 45'(14 * 8)] = mk(32'h0055, 16'h0000);

    repeat (3) @(negedge clk);
    // reset state
    chk(rsp_valid == 0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(mem_req_valid == 0, "R11", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);
    chk(busy == 0, "R10", "reset busy", 64'(busy), 64'h0);
    @(posedge clk); #2; rst_n = 1;

    do_walk(va_of(5, 7, 9, 16), 3'b001, 2'd0, "R7");   // kernel read ok
    do_walk(va_of(5, 7, 10, 0), 3'b010, 2'd0, "R7");   // write not granted
    do_walk(va_of(5, 7, 11, 0), 3'b010, 2'd3, "R7");   // user write ok
    do_walk(va_of(5, 7, 11, 0), 3'b001, 2'd0, "R7");   // kernel bits clear
    do_walk(va_of(5, 7, 12, 0), 3'b100, 2'd0, "R8");   // fault on execute
    do_walk(va_of(5, 7, 12, 0), 3'b001, 2'd0, "R8");   // read survives
    do_walk(va_of(5, 7, 13, 0), 3'b110, 2'd0, "R8");   // execute beats write
    do_walk(va_of(5, 7, 13, 0), 3'b011, 2'd0, "R8");   // write beats read
    do_walk(va_of(5, 7, 13, 0), 3'b001, 2'd0, "R8");   // fault on read
    do_walk(va_of(5, 7, 13, 0), 3'b000, 2'd0, "R9");   // no need
    do_walk(va_of(5, 7, 14, 0), 3'b001, 2'd0, "R5");   // leaf invalid
    do_walk(va_of(6, 0, 0, 0),  3'b001, 2'd0, "R5");   // level 0 invalid
    do_walk(va_of(5, 8, 0, 0),  3'b001, 2'd0, "R5");   // level 1 invalid
    do_walk(va_of(7, 0, 0, 0),  3'b001, 2'd0, "R6");   // level 0 no kernel read
    do_walk(va_of(5, 9, 0, 0),  3'b001, 2'd0, "R6");   // level 1 no kernel read
    do_walk(64'h0000_1000_0000_0000, 3'b001, 2'd0, "R1");
    do_walk(64'h8000_0000_0000_0000, 3'b001, 2'd0, "R1");
    do_walk(64'hFFFF_F800_0000_0000, 3'b001, 2'd0, "R1");  // well-formed, walks
    do_walk(64'hFFFF_FD12_3456_7890, 3'b010, 2'd0, "R2");
    do_walk(64'hFFFF_FC00_0000_1FFF, 3'b100, 2'd0, "R2");
    do_walk(64'hFFFF_FD12_3456_7890, 3'b001, 2'd1, "R3");
    do_walk(64'hFFFF_FC00_0000_0000, 3'b000, 2'd3, "R3");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule